// File: doc/BRIEF.md
# Compare-Value Deadline Timer

This block pairs a free-running system counter with a single comparator timer. Software sets a deadline either as an absolute compare value held at the full counter width, or through a signed 32-bit relative view that is computed from the live counter. Both views describe the same stored deadline, so reading one after writing the other gives a consistent answer. A control word carries an enable bit, an interrupt mask bit and a read-only status bit, and the block drives one level-sensitive interrupt line.

The counter advances on a tick-enable input and can be overwritten by software. Moving the counter forward past the deadline fires the timer, and moving it back below the deadline cancels a pending interrupt. The counter width is a parameter from 56 to 64 bits, and every compare arithmetic wraps at that width.

Top module: `cmp_deadline_timer`

## Requirements
- R1: The register port selects by `reg_addr`: 0 = counter, 1 = absolute deadline, 2 = relative view, 3 = control. In the control word, bit 0 is enable (read/write), bit 1 is mask (read/write), bit 2 is status (read-only) and the other bits read 0. Counter and deadline reads are zero-extended to 64 bits. `reg_rdata` is combinational from `reg_addr` and shows the values held before any write in the same cycle.
- R2: The counter adds one in every cycle in which `tick_en` is high and wraps from all ones to zero at CNT_W bits. A counter write in the same cycle wins over the increment.
- R3: The timer condition is the unsigned full-width comparison counter >= deadline. Status reads 1 exactly when enable is 1 and the condition holds. After reset the counter and deadline are 0, enable is 0 and mask is 1.
- R4: `irq` is a register that loads (enable AND NOT mask AND condition) at each clock edge, so it follows any change of counter, deadline or control word one cycle later.
- R5: When mask is 1, `irq` stays low while status is still evaluated. Clearing mask while the condition holds and enable is 1 raises `irq` one cycle later.
- R6: A relative-view read returns (deadline - counter) truncated to 32 bits and sign-extended to 64 bits, so the value keeps falling through zero into negative numbers.
- R7: A relative-view write sets the deadline to counter + sign-extended `reg_wdata[31:0]`, modulo 2^CNT_W, using the counter value before the clock edge. A negative value written near counter zero gives a deadline close to the all-ones maximum.
- R8: An absolute deadline is stored at full CNT_W width, so a deadline more than 2^31-1 ticks ahead does not fire early.
- R9: Writing the counter to a value at or above the deadline makes the condition true. Writing it back below the deadline clears the condition and drops a pending `irq`.
- R10: A new deadline write replaces the old one entirely, whether it is earlier or later than the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advances by one when high |
| reg_we | input | 1 | Write strobe for the register selected by `reg_addr` |
| reg_addr | input | 2 | Register select (0 counter, 1 deadline, 2 relative, 3 control) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| irq | output | 1 | Level-sensitive timer interrupt |

## Verification
The bench builds the block with a 56-bit counter, the narrowest allowed width, so the wrap of the counter and of relative writes at 2^56 can be reached by loading the counter a few ticks below all ones. That width is still far above the 32-bit relative range, which lets the bench place a deadline 2^31+20 ticks ahead and observe that it stays quiet and that the relative view reads as a negative number. Counter writes forward and backward across the deadline, reprogramming in both directions and mask toggles are all driven through the register port and compared with a behavioural model every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_DW = 64;
  localparam int REL_W  = 32;

  typedef enum logic [1:0] {
    SEL_COUNT    = 2'd0,
    SEL_DEADLINE = 2'd1,
    SEL_RELATIVE = 2'd2,
    SEL_CONTROL  = 2'd3
  } reg_sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = load_en | tick_en;
    if (load_en) cnt_d = load_val;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_en) && !$past(load_en)) |-> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_en) |-> (cnt_q == $past(load_val)));
endmodule

// File: rtl/tmr_deadline.sv
module tmr_deadline
  import tmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              abs_we,
  input  logic              rel_we,
  input  logic [REG_DW-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [REL_W-1:0]  rel_o,
  output logic              cond_o
);
  logic [CNT_W-1:0] cmp_d;
  logic [CNT_W-1:0] rel_ext;
  logic [CNT_W-1:0] diff;
  logic             cmp_ce;

  always_comb begin
    rel_ext = CNT_W'($signed(wdata[REL_W-1:0]));
    cmp_ce  = abs_we | rel_we;
    if (abs_we) cmp_d = wdata[CNT_W-1:0];
    else        cmp_d = cnt_i + rel_ext;
    diff    = cmp_q - cnt_i;
    rel_o   = diff[REL_W-1:0];
    cond_o  = (cnt_i >= cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_ce) cmp_q <= cmp_d;
  end

  assert_rel_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rel_we) && !$past(abs_we)) |->
      (cmp_q == CNT_W'($past(cnt_i) + CNT_W'($signed($past(wdata[REL_W-1:0]))))));

  assert_abs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abs_we) |-> (cmp_q == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [REG_DW-1:0] wdata,
  input  logic              cond_i,
  output logic              en_q,
  output logic              mask_q,
  output logic              status_o,
  output logic              irq_o
);
  logic en_d, mask_d, irq_d;

  always_comb begin
    en_d     = ctl_we ? wdata[CTL_EN_BIT]   : en_q;
    mask_d   = ctl_we ? wdata[CTL_MASK_BIT] : mask_q;
    status_o = en_q & cond_i;
    irq_d    = status_o & ~mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b1;
      irq_o  <= 1'b0;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
      irq_o  <= irq_d;
    end
  end

  assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q) |-> !irq_o);
endmodule

// File: rtl/cmp_deadline_timer.sv
module cmp_deadline_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        irq
);
  reg_sel_e         sel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic [REL_W-1:0] rel;
  logic             cond, en, mask, status;
  logic             we_cnt, we_abs, we_rel, we_ctl;

  always_comb begin
    sel    = reg_sel_e'(reg_addr);
    we_cnt = reg_we & (sel == SEL_COUNT);
    we_abs = reg_we & (sel == SEL_DEADLINE);
    we_rel = reg_we & (sel == SEL_RELATIVE);
    we_ctl = reg_we & (sel == SEL_CONTROL);
  end

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_en  (we_cnt),
    .load_val (reg_wdata[CNT_W-1:0]),
    .cnt_q    (cnt)
  );

  tmr_deadline #(.CNT_W(CNT_W)) u_deadline (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt),
    .abs_we (we_abs),
    .rel_we (we_rel),
    .wdata  (reg_wdata),
    .cmp_q  (cmp),
    .rel_o  (rel),
    .cond_o (cond)
  );

  tmr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (we_ctl),
    .wdata    (reg_wdata),
    .cond_i   (cond),
    .en_q     (en),
    .mask_q   (mask),
    .status_o (status),
    .irq_o    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_COUNT:    reg_rdata = REG_DW'(cnt);
      SEL_DEADLINE: reg_rdata = REG_DW'(cmp);
      SEL_RELATIVE: reg_rdata = REG_DW'($signed(rel));
      SEL_CONTROL: begin
        reg_rdata[CTL_EN_BIT]   = en;
        reg_rdata[CTL_MASK_BIT] = mask;
        reg_rdata[CTL_STAT_BIT] = status;
      end
      default: reg_rdata = '0;
    endcase
  end

  assert_irq_from_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(status));
endmodule

// File: tb/cmp_deadline_timer_bench.sv
module cmp_deadline_timer_bench;
  localparam int CNT_W = 56;
  localparam longint unsigned MSK = (64'd1 << CNT_W) - 64'd1;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  longint unsigned m_cnt, m_cmp;
  bit m_en, m_mask, m_irq;

  cmp_deadline_timer #(.CNT_W(CNT_W)) u_cmp_deadline_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] model_read(input logic [1:0] a);
    logic [31:0] d;
    bit c;
    c = (m_cnt >= m_cmp);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_cmp;
      2'd2: begin d = 32'(m_cmp - m_cnt); return {{32{d[31]}}, d}; end
      default: return {61'd0, m_en & c, m_mask, m_en};
    endcase
  endfunction

  task automatic cmp_val(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [63:0] d, input bit tk, input string tag);
    longint unsigned s;
    bit c;
    reg_we = we; reg_addr = a; reg_wdata = d; tick_en = tk;
    #1;
    cmp_val(tag, "rdata", reg_rdata, model_read(a));
    cmp_val(tag, "irq", {63'd0, irq}, {63'd0, m_irq});
    @(posedge clk);
    c = (m_cnt >= m_cmp);
    m_irq = m_en & ~m_mask & c;
    s = {{32{d[31]}}, d[31:0]};
    if (we && a == 2'd1) m_cmp = d & MSK;
    if (we && a == 2'd2) m_cmp = (m_cnt + s) & MSK;
    if (we && a == 2'd3) begin m_en = d[0]; m_mask = d[1]; end
    if (we && a == 2'd0) m_cnt = d & MSK;
    else if (tk) m_cnt = (m_cnt + 64'd1) & MSK;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [1:0] a, input bit tk, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, a, 64'd0, tk, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_cmp = 0; m_en = 0; m_mask = 1; m_irq = 0;
    rst_n = 1'b0; tick_en = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R3 reset state
    step(0, 2'd3, 0, 0, "R3");
    step(0, 2'd0, 0, 0, "R1");
    step(0, 2'd1, 0, 0, "R1");
    // R2 counting with gaps
    idle(4, 2'd0, 1, "R2");
    idle(2, 2'd0, 0, "R2");
    // R3 R4 absolute deadline fires
    step(1, 2'd1, 64'd12, 1, "R3");
    step(1, 2'd3, 64'd1, 1, "R4");
    idle(10, 2'd3, 1, "R4");
    // R6 relative view counts past zero
    idle(4, 2'd2, 1, "R6");
    // R5 mask keeps status, blocks irq; unmask raises
    step(1, 2'd3, 64'd3, 1, "R5");
    idle(3, 2'd3, 1, "R5");
    step(1, 2'd3, 64'd1, 0, "R5");
    idle(3, 2'd3, 0, "R5");
    // R9 counter back below deadline cancels, forward again fires
    step(1, 2'd0, 64'd2, 0, "R9");
    idle(3, 2'd3, 0, "R9");
    step(1, 2'd0, 64'd500, 0, "R9");
    idle(3, 2'd3, 0, "R9");
    // R7 negative relative write near zero wraps to near max
    step(1, 2'd0, 64'd3, 0, "R7");
    step(1, 2'd2, 64'hFFFF_FFF6, 0, "R7");
    step(0, 2'd1, 0, 0, "R7");
    step(0, 2'd2, 0, 1, "R7");
    idle(3, 2'd3, 1, "R7");
    // R8 far deadline beyond the 32-bit relative range
    step(1, 2'd0, 64'd100, 0, "R8");
    step(1, 2'd1, 64'd100 + (64'd1 << 31) + 64'd20, 1, "R8");
    idle(8, 2'd3, 1, "R8");
    step(0, 2'd2, 0, 1, "R8");
    step(1, 2'd0, 64'd100 + (64'd1 << 31) + 64'd17, 1, "R8");
    idle(6, 2'd3, 1, "R8");
    // R10 reprogram later to earlier
    step(1, 2'd3, 64'd3, 0, "R10");
    step(1, 2'd0, 64'd1000, 0, "R10");
    step(1, 2'd2, 64'd60, 0, "R10");
    step(1, 2'd2, 64'd4, 0, "R10");
    step(1, 2'd3, 64'd1, 1, "R10");
    idle(8, 2'd3, 1, "R10");
    // R10 earlier to later
    step(1, 2'd2, 64'd3, 0, "R10");
    step(1, 2'd2, 64'd40, 1, "R10");
    idle(10, 2'd3, 1, "R10");
    idle(2, 2'd2, 1, "R10");
    // R2 wrap at counter width and write priority over tick
    step(1, 2'd0, MSK - 64'd1, 1, "R2");
    idle(4, 2'd0, 1, "R2");
    step(1, 2'd0, 64'd77, 1, "R2");
    idle(2, 2'd0, 1, "R2");
    // R1 upper write bits beyond counter width are dropped
    step(1, 2'd0, 64'hFFFF_0000_0000_0005, 0, "R1");
    step(0, 2'd0, 0, 0, "R1");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule